// File: doc/BRIEF.md
# Transmit Clock Oscillator with Reference Watch

This block is a numerically controlled oscillator that runs from a fast system clock and produces a one-cycle output clock enable. The output rate is nominally 2.048 MHz in E1 line mode and 1.544 MHz in T1 line mode. A phase accumulator advances by a frequency word on every system clock, and each carry out of the accumulator is one output clock pulse. The block exposes that frequency word so downstream logic can see the rate in use.

The oscillator follows a reference clock enable through a first-order loop. On each reference pulse it samples the accumulator phase and sets the frequency word to the nominal value plus a correction. The correction is the phase error, shifted right by a programmable amount and clamped to a fixed deviation. The loop attenuates jitter above its corner frequency at 20 dB per decade and lets slow wander through. A watch circuit counts reference periods that go missing. Up to three missing periods are bridged without any change in behaviour. From the fourth one onward the reference is flagged as lost, and the oscillator holds over. In holdover it either returns to nominal or keeps its last frequency, as chosen by a center-enable input.

Top module: `dco_tx_osc`

## Requirements
- R1: After reset the accumulator and the correction are zero and `ref_lost` is low. `freq_word` equals the nominal step floor(f_out·2^ACC_W / f_sys), which is 0x1000_0000 for E1 and 0x0C10_0000 for T1 with the defaults (f_sys = 32.768 MHz, ACC_W = 32).
- R2: The accumulator adds `freq_word` on every clock. `out_pulse` is high for exactly the one cycle after an addition that carries out of bit ACC_W-1. From reset in E1 mode with no correction, the first pulse shows after clock edge 16 and then every 16 edges.
- R3: A reference pulse sampled at an edge loads the correction with -(E >>> `loop_shift`), where E is the signed value of the top ERR_W (default 24) bits of the accumulator before that edge. The new `freq_word` applies from the next cycle.
- R4: The correction is clamped to ±MAX_DEV (default 2^20), so `freq_word` always stays within MAX_DEV of the nominal step of the current mode.
- R5: A missing reference period is counted when no reference pulse has been seen for floor(1.5 nominal periods) system clocks: 24 in E1 and 31 in T1. Each further missing period is counted one nominal period later (16 in E1, 21 in T1).
- R6: While one, two or three periods are missing, `ref_lost` stays low and `freq_word` does not change, whatever `center_en` is.
- R7: The fourth missing period raises `ref_lost`. In E1 this happens 72 edges after the last reference pulse or after reset.
- R8: While `ref_lost` is high and `center_en` is high, the correction returns to zero at the next edge, so `freq_word` is the nominal step.
- R9: While `ref_lost` is high and `center_en` is low, the correction is held, so `freq_word` keeps its last value.
- R10: A reference pulse clears the missing-period count and `ref_lost` at the edge that samples it. This holds even when that edge is the one that would have counted the fourth missing period. The pulse also loads a new correction.
- R11: `mode_t1` selects the nominal step right away, in the same cycle, and also selects the period lengths used by the watch. In T1, `ref_lost` rises 94 edges after the last reference pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_pulse | input | 1 | One-cycle reference clock enable |
| mode_t1 | input | 1 | 0 selects E1 rates, 1 selects T1 rates |
| center_en | input | 1 | Holdover choice: 1 returns to nominal, 0 freezes the frequency |
| loop_shift | input | GAIN_W | Right shift applied to the phase error; sets the loop corner frequency |
| out_pulse | output | 1 | One-cycle output clock enable |
| ref_lost | output | 1 | High once four consecutive reference periods are missing |
| freq_word | output | ACC_W | Frequency word currently added to the accumulator |

## Verification
Two functions of the block can fall on the same edge. The watch can reach its fourth missing period on the very edge that samples a late reference pulse. When that happens the pulse must win: `ref_lost` stays low and a fresh correction is loaded. The bench provokes this by placing a reference pulse exactly 72 edges after the previous one. It then checks `ref_lost` on that edge and the next one, and checks `freq_word` against the correction computed from the accumulator phase. Random gaps of 20 to 130 cycles also land on and around every threshold, and a cycle-accurate bench model judges each of those cycles.

// File: rtl/dco_pkg.sv
package dco_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [0:0] {
      LINE_E1 = 1'b0,
      LINE_T1 = 1'b1
   } line_mode_e;

   // accumulator step for a wanted output rate
   function automatic longint unsigned nco_step(input int unsigned out_khz,
                                                input int unsigned sys_khz,
                                                input int unsigned acc_w);
      return (longint'(out_khz) << acc_w) / longint'(sys_khz);
   endfunction

   // nominal period in system clocks (floor)
   function automatic int unsigned period_cycles(input int unsigned out_khz,
                                                 input int unsigned sys_khz);
      return sys_khz / out_khz;
   endfunction

   // one and a half nominal periods in system clocks (floor)
   function automatic int unsigned gap_cycles(input int unsigned out_khz,
                                              input int unsigned sys_khz);
      return (3 * sys_khz) / (2 * out_khz);
   endfunction
endpackage

// File: rtl/dco_ref_watch.sv
module dco_ref_watch #(
   parameter int unsigned GAP_W      = 5,
   parameter int unsigned MISS_LIMIT = 4,
   parameter int unsigned E1_PER     = 16,
   parameter int unsigned E1_GAP     = 24,
   parameter int unsigned T1_PER     = 21,
   parameter int unsigned T1_GAP     = 31
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_pulse,
   input  logic mode_t1,
   output logic ref_lost
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned MW = $clog2(MISS_LIMIT + 1);

   logic [GAP_W-1:0] gap_q;
   logic [GAP_W-1:0] gap_last;
   logic [GAP_W-1:0] gap_rewind;
   logic [MW-1:0]    miss_q;
   logic             miss_full;

   // last count before a period is declared missing, and where counting resumes
   always_comb begin
      if (mode_t1) begin
         gap_last   = GAP_W'(T1_GAP - 1);
         gap_rewind = GAP_W'(T1_GAP - T1_PER);
      end else begin
         gap_last   = GAP_W'(E1_GAP - 1);
         gap_rewind = GAP_W'(E1_GAP - E1_PER);
      end
   end

   assign miss_full = (miss_q == MW'(MISS_LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         miss_q <= '0;
      end else if (ref_pulse) begin
         gap_q  <= '0;
         miss_q <= '0;
      end else if (gap_q >= gap_last) begin
         gap_q <= gap_rewind;
         if (!miss_full) begin
            miss_q <= miss_q + MW'(1);
         end
      end else begin
         gap_q <= gap_q + GAP_W'(1);
      end
   end

   assign ref_lost = miss_full;
endmodule

// File: rtl/dco_phase_acc.sv
module dco_phase_acc #(
   parameter int unsigned ACC_W = 32,
   parameter int unsigned ERR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] step,
   output logic [ERR_W-1:0] phase_msb,
   output logic             wrap_pulse
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum;

   assign sum = {1'b0, acc_q} + {1'b0, step};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q      <= '0;
         wrap_pulse <= 1'b0;
      end else begin
         acc_q      <= sum[ACC_W-1:0];
         wrap_pulse <= sum[ACC_W];
      end
   end

   assign phase_msb = acc_q[ACC_W-1 -: ERR_W];
endmodule

// File: rtl/dco_loop_filter.sv
module dco_loop_filter #(
   parameter int unsigned ERR_W   = 24,
   parameter int unsigned OFF_W   = 28,
   parameter int unsigned GAIN_W  = 4,
   parameter int unsigned MAX_DEV = 1048576
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ref_pulse,
   input  logic                    ref_lost,
   input  logic                    center_en,
   input  logic [GAIN_W-1:0]       loop_shift,
   input  logic [ERR_W-1:0]        phase_msb,
   output logic signed [OFF_W-1:0] offset
);
   timeunit 1ns;
   timeprecision 1ps;

   // working width: holds the negated error and the clamp limits
   localparam int unsigned CW = (ERR_W + 1 > OFF_W) ? ERR_W + 1 : OFF_W;
   localparam logic signed [CW:0]      LIM_HI  = (CW + 1)'(MAX_DEV);
   localparam logic signed [CW:0]      LIM_LO  = -LIM_HI;
   localparam logic signed [OFF_W-1:0] OFF_HI  = OFF_W'(MAX_DEV);
   localparam logic signed [OFF_W-1:0] OFF_LO  = -OFF_HI;

   logic signed [CW:0]      err_x;
   logic signed [CW:0]      corr_raw;
   logic signed [OFF_W-1:0] off_next;
   logic signed [OFF_W-1:0] off_q;

   assign err_x    = {{(CW + 1 - ERR_W){phase_msb[ERR_W-1]}}, phase_msb};
   assign corr_raw = -(err_x >>> loop_shift);

   always_comb begin
      if (corr_raw > LIM_HI) begin
         off_next = OFF_HI;
      end else if (corr_raw < LIM_LO) begin
         off_next = OFF_LO;
      end else begin
         off_next = corr_raw[OFF_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= '0;
      end else if (ref_pulse) begin
         off_q <= off_next;
      end else if (ref_lost && center_en) begin
         off_q <= '0;
      end
   end

   assign offset = off_q;
endmodule

// File: rtl/dco_tx_osc.sv
module dco_tx_osc #(
   parameter int unsigned ACC_W      = 32,
   parameter int unsigned SYS_KHZ    = 32768,
   parameter int unsigned E1_KHZ     = 2048,
   parameter int unsigned T1_KHZ     = 1544,
   parameter int unsigned ERR_W      = 24,
   parameter int unsigned OFF_W      = 28,
   parameter int unsigned MAX_DEV    = 1048576,
   parameter int unsigned MISS_LIMIT = 4,
   parameter int unsigned GAIN_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_pulse,
   input  logic              mode_t1,
   input  logic              center_en,
   input  logic [GAIN_W-1:0] loop_shift,
   output logic              out_pulse,
   output logic              ref_lost,
   output logic [ACC_W-1:0]  freq_word
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [ACC_W-1:0] E1_STEP = ACC_W'(dco_pkg::nco_step(E1_KHZ, SYS_KHZ, ACC_W));
   localparam logic [ACC_W-1:0] T1_STEP = ACC_W'(dco_pkg::nco_step(T1_KHZ, SYS_KHZ, ACC_W));
   localparam int unsigned E1_PER  = dco_pkg::period_cycles(E1_KHZ, SYS_KHZ);
   localparam int unsigned T1_PER  = dco_pkg::period_cycles(T1_KHZ, SYS_KHZ);
   localparam int unsigned E1_GAP  = dco_pkg::gap_cycles(E1_KHZ, SYS_KHZ);
   localparam int unsigned T1_GAP  = dco_pkg::gap_cycles(T1_KHZ, SYS_KHZ);
   localparam int unsigned GAP_MAX = (E1_GAP > T1_GAP) ? E1_GAP : T1_GAP;
   localparam int unsigned GAP_W   = $clog2(GAP_MAX + 1);

   // elaboration-time parameter checks
   if (ACC_W < 8 || ACC_W > 48) begin : g_bad_acc
      $error("dco_tx_osc: ACC_W out of range");
   end
   if (ERR_W < 2 || ERR_W > ACC_W) begin : g_bad_err
      $error("dco_tx_osc: ERR_W must lie in 2..ACC_W");
   end
   if (OFF_W < 2 || OFF_W > ACC_W) begin : g_bad_off
      $error("dco_tx_osc: OFF_W must lie in 2..ACC_W");
   end
   if (MAX_DEV == 0 || longint'(MAX_DEV) >= (longint'(1) << (OFF_W - 1))) begin : g_bad_dev
      $error("dco_tx_osc: MAX_DEV does not fit the correction width");
   end
   if (MAX_DEV >= T1_STEP || MAX_DEV >= E1_STEP) begin : g_bad_step
      $error("dco_tx_osc: MAX_DEV reaches the nominal step");
   end
   if (E1_KHZ * 4 > SYS_KHZ || T1_KHZ * 4 > SYS_KHZ) begin : g_bad_sys
      $error("dco_tx_osc: system clock too slow for the output rates");
   end
   if (MISS_LIMIT < 1) begin : g_bad_miss
      $error("dco_tx_osc: MISS_LIMIT must be at least one");
   end
   if (GAIN_W < 1 || GAIN_W > 6) begin : g_bad_gain
      $error("dco_tx_osc: GAIN_W out of range");
   end

   dco_pkg::line_mode_e line_sel;
   logic [ACC_W-1:0]        nom_step;
   logic [ACC_W-1:0]        off_ext;
   logic signed [OFF_W-1:0] offset;
   logic [ERR_W-1:0]        phase_msb;

   assign line_sel = dco_pkg::line_mode_e'(mode_t1);
   assign nom_step = (line_sel == dco_pkg::LINE_T1) ? T1_STEP : E1_STEP;

   if (OFF_W < ACC_W) begin : g_off_sext
      assign off_ext = {{(ACC_W - OFF_W){offset[OFF_W-1]}}, offset};
   end else begin : g_off_full
      assign off_ext = offset;
   end

   assign freq_word = nom_step + off_ext;

   dco_ref_watch #(
      .GAP_W     (GAP_W),
      .MISS_LIMIT(MISS_LIMIT),
      .E1_PER    (E1_PER),
      .E1_GAP    (E1_GAP),
      .T1_PER    (T1_PER),
      .T1_GAP    (T1_GAP)
   ) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_pulse(ref_pulse),
      .mode_t1  (mode_t1),
      .ref_lost (ref_lost)
   );

   dco_phase_acc #(
      .ACC_W(ACC_W),
      .ERR_W(ERR_W)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (freq_word),
      .phase_msb (phase_msb),
      .wrap_pulse(out_pulse)
   );

   dco_loop_filter #(
      .ERR_W  (ERR_W),
      .OFF_W  (OFF_W),
      .GAIN_W (GAIN_W),
      .MAX_DEV(MAX_DEV)
   ) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_pulse (ref_pulse),
      .ref_lost  (ref_lost),
      .center_en (center_en),
      .loop_shift(loop_shift),
      .phase_msb (phase_msb),
      .offset    (offset)
   );
endmodule

// File: rtl/dco_tx_osc_chk.sv
module dco_tx_osc_chk #(
   parameter int unsigned     ACC_W   = 32,
   parameter longint unsigned E1_STEP = 64'h1000_0000,
   parameter longint unsigned T1_STEP = 64'h0C10_0000,
   parameter int unsigned     MAX_DEV = 1048576
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ref_pulse,
   input logic             mode_t1,
   input logic             center_en,
   input logic             out_pulse,
   input logic             ref_lost,
   input logic [ACC_W-1:0] freq_word
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [ACC_W-1:0]        E1_W   = ACC_W'(E1_STEP);
   localparam logic [ACC_W-1:0]        T1_W   = ACC_W'(T1_STEP);
   localparam logic signed [ACC_W-1:0] DEV_HI = ACC_W'(MAX_DEV);
   localparam logic signed [ACC_W-1:0] DEV_LO = -DEV_HI;

   logic signed [ACC_W-1:0] off_obs;
   assign off_obs = freq_word - (mode_t1 ? T1_W : E1_W);

   // R10
   ref_clears_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pulse |=> !ref_lost);

   // R8
   center_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_lost && center_en && !ref_pulse) |=> (off_obs == '0));

   // R6
   hold_between_refs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_pulse && !(ref_lost && center_en)) |=> $stable(off_obs));

   // R4
   dev_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (off_obs <= DEV_HI) && (off_obs >= DEV_LO));

   // R2
   pulse_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_pulse |=> !out_pulse);

   // R7
   loss_needs_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_lost) |-> !$past(ref_pulse));
endmodule

bind dco_tx_osc dco_tx_osc_chk #(
   .ACC_W  (ACC_W),
   .E1_STEP(E1_STEP),
   .T1_STEP(T1_STEP),
   .MAX_DEV(MAX_DEV)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ref_pulse(ref_pulse),
   .mode_t1  (mode_t1),
   .center_en(center_en),
   .out_pulse(out_pulse),
   .ref_lost (ref_lost),
   .freq_word(freq_word)
);

// File: tb/dco_tx_osc_test.sv
module dco_tx_osc_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [31:0] E1_NOM = 32'h1000_0000;
   localparam logic [31:0] T1_NOM = 32'h0C10_0000;
   localparam int          DEV    = 1 << 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_pulse = 1'b0;
   logic        mode_t1 = 1'b0;
   logic        center_en = 1'b0;
   logic [3:0]  loop_shift = 4'd0;
   logic        out_pulse;
   logic        ref_lost;
   logic [31:0] freq_word;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   dco_tx_osc uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_pulse (ref_pulse),
      .mode_t1   (mode_t1),
      .center_en (center_en),
      .loop_shift(loop_shift),
      .out_pulse (out_pulse),
      .ref_lost  (ref_lost),
      .freq_word (freq_word)
   );

   // ---------------- expected-value functions ----------------
   function automatic logic [31:0] nom_of(input logic t1);
      return t1 ? T1_NOM : E1_NOM;
   endfunction

   function automatic int gap_of(input logic t1);
      return t1 ? 31 : 24;
   endfunction

   function automatic int per_of(input logic t1);
      return t1 ? 21 : 16;
   endfunction

   function automatic int corr_of(input logic [31:0] acc, input int sh);
      int e;
      int c;
      e = int'($signed(acc[31:8]));
      c = -(e >>> sh);
      if (c > DEV) c = DEV;
      if (c < -DEV) c = -DEV;
      return c;
   endfunction

   // ---------------- cycle model built from the requirements ----------------
   logic [31:0] m_acc;
   logic        m_pulse;
   int          m_off;
   int          m_gap;
   int          m_miss;
   logic [31:0] m_inc;

   assign m_inc = nom_of(mode_t1) + 32'(m_off);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_acc   <= '0;
         m_pulse <= 1'b0;
         m_off   <= 0;
         m_gap   <= 0;
         m_miss  <= 0;
      end else begin
         {m_pulse, m_acc} <= {1'b0, m_acc} + {1'b0, m_inc};
         if (ref_pulse) begin
            m_off  <= corr_of(m_acc, int'(loop_shift));
            m_gap  <= 0;
            m_miss <= 0;
         end else begin
            if (m_miss == 4 && center_en) m_off <= 0;
            if (m_gap >= gap_of(mode_t1) - 1) begin
               m_gap <= gap_of(mode_t1) - per_of(mode_t1);
               if (m_miss < 4) m_miss <= m_miss + 1;
            end else begin
               m_gap <= m_gap + 1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // every cycle: outputs against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(out_pulse === m_pulse, "R2 out_pulse", longint'(out_pulse), longint'(m_pulse));
         chk(ref_lost === (m_miss == 4), "R7 ref_lost", longint'(ref_lost), longint'(m_miss == 4));
         chk(freq_word === m_inc, "R3 freq_word", longint'(freq_word), longint'(m_inc));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic pulse_ref();
      ref_pulse = 1'b1;
      tick();
      ref_pulse = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      chk(freq_word == nom_of(mode_t1), "R1 reset freq_word", longint'(freq_word), longint'(nom_of(mode_t1)));
      chk(ref_lost == 1'b0, "R1 reset ref_lost", longint'(ref_lost), 0);
      chk(out_pulse == 1'b0, "R1 reset out_pulse", longint'(out_pulse), 0);
      rst_n = 1'b1;
   endtask

   // watchdog
   initial begin
      #950000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int first_idx;
      int npulse;
      void'($urandom(32'd4711));

      // ---- R1, R2, R5/R7 from reset in E1 ----
      mode_t1 = 1'b0;
      do_reset();
      first_idx = -1;
      npulse = 0;
      for (int k = 1; k <= 64; k++) begin
         tick();
         if (out_pulse) begin
            npulse++;
            if (first_idx < 0) first_idx = k;
         end
      end
      chk(first_idx == 16, "R2 first wrap edge", first_idx, 16);
      chk(npulse == 4, "R2 pulses in 64 edges", npulse, 4);
      repeat (7) tick();
      chk(ref_lost == 1'b0, "R5 no loss at edge 71", longint'(ref_lost), 0);
      tick();
      chk(ref_lost == 1'b1, "R7 loss at edge 72", longint'(ref_lost), 1);

      // ---- R4: gain 0, phase 2^29 at the sampled edge -> clamp to -DEV ----
      loop_shift = 4'd0;
      center_en = 1'b0;
      do_reset();
      tick();
      tick();
      pulse_ref();
      chk(freq_word == E1_NOM - 32'(DEV), "R4 clamp low", longint'(freq_word), longint'(E1_NOM - 32'(DEV)));
      repeat (100) tick();
      chk(ref_lost == 1'b1, "R7 lost after silence", longint'(ref_lost), 1);
      chk(freq_word == E1_NOM - 32'(DEV), "R9 frozen in holdover", longint'(freq_word), longint'(E1_NOM - 32'(DEV)));

      // ---- R3, R6, R10, R8 ----
      loop_shift = 4'd2;
      do_reset();
      tick();
      tick();
      pulse_ref();
      chk(freq_word == E1_NOM - 32'(1 << 19), "R3 shifted correction", longint'(freq_word), longint'(E1_NOM - 32'(1 << 19)));
      center_en = 1'b1;
      repeat (71) tick();
      chk(ref_lost == 1'b0, "R6 three misses bridged", longint'(ref_lost), 0);
      chk(freq_word == E1_NOM - 32'(1 << 19), "R6 frequency kept", longint'(freq_word), longint'(E1_NOM - 32'(1 << 19)));
      pulse_ref();
      chk(ref_lost == 1'b0, "R10 ref wins at threshold", longint'(ref_lost), 0);
      chk(freq_word == m_inc, "R10 new correction", longint'(freq_word), longint'(m_inc));
      tick();
      chk(ref_lost == 1'b0, "R10 still clear", longint'(ref_lost), 0);
      repeat (72) tick();
      chk(ref_lost == 1'b1, "R8 lost", longint'(ref_lost), 1);
      chk(freq_word == E1_NOM, "R8 centered", longint'(freq_word), longint'(E1_NOM));

      // ---- R3 negative error, R11 mode switch ----
      center_en = 1'b0;
      do_reset();
      repeat (14) tick();
      pulse_ref();
      chk(freq_word == E1_NOM + 32'(1 << 19), "R3 negative error", longint'(freq_word), longint'(E1_NOM + 32'(1 << 19)));
      mode_t1 = 1'b1;
      #1;
      chk(freq_word == T1_NOM + 32'(1 << 19), "R11 T1 step at once", longint'(freq_word), longint'(T1_NOM + 32'(1 << 19)));
      pulse_ref();
      repeat (93) tick();
      chk(ref_lost == 1'b0, "R11 T1 no loss at 93", longint'(ref_lost), 0);
      tick();
      chk(ref_lost == 1'b1, "R11 T1 loss at 94", longint'(ref_lost), 1);

      // ---- constrained random ----
      mode_t1 = 1'b0;
      do_reset();
      for (int i = 0; i < 2500; i++) begin
         int r;
         int wait_n;
         r = int'($urandom_range(0, 99));
         if (r < 3) mode_t1 = ~mode_t1;
         if (r < 10) center_en = 1'($urandom_range(0, 1));
         if (r < 14) loop_shift = 4'($urandom_range(0, 15));
         if (r < 85) begin
            wait_n = per_of(mode_t1) - 3 + int'($urandom_range(0, 4));
         end else if (r < 90) begin
            wait_n = (mode_t1 ? 93 : 71);
         end else begin
            wait_n = int'($urandom_range(20, 130));
         end
         repeat (wait_n) tick();
         pulse_ref();
      end
      repeat (150) tick();

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule